// File: doc/BRIEF.md
# Conditional Branch Resolver with Single Delay Slot

This block decides whether a conditional branch is taken and where it goes. It takes the four condition flags (zero, negative, overflow, carry) as they stand after the preceding instruction. It also takes a three-bit condition selector with a separate invert bit, and a target-source selection. From these it produces a taken decision and the next fetch address in the same cycle. The target comes from one of three sources: an absolute word address built from a 23-bit constant, a signed word offset added to the current program counter, or the sum of two register operands. The register operands serve the register-based branch variant.

A small sequencer follows each taken branch. It holds the target while exactly one following instruction, the delay slot, issues, and then raises a one-cycle redirect that carries the held target. The sequencer's states are IDLE (nothing pending), SLOT (a target is held and the delay-slot instruction is awaited) and FIRE (the redirect is presented for one cycle). Its transitions are:
- arm: IDLE or FIRE to SLOT, when a taken branch issues.
- wait: SLOT to SLOT, while no instruction issues.
- release: SLOT to FIRE, when the delay-slot instruction issues.
- settle: FIRE to IDLE, when no taken branch issues.

Top module: `brc_unit`

## Requirements
- R1: With `inv`=0 and `br_en`=1, `taken` is the predicate chosen by `cond`: 0 always true; 1 C and not Z; 2 not C; 3 not Z; 4 not V; 5 not N; 6 N equal to V; 7 (N equal to V) and not Z.
- R2: With `inv`=1 the chosen predicate is negated, so code 0 never branches and code 7 gives Z or (N differs from V).
- R3: When taken with `rel`=0 and `br_reg`=0, `target` is the 23-bit constant zero-extended and multiplied by 4 (range 0 to 2^25-4).
- R4: When taken with `rel`=1 and `br_reg`=0, `target` is `pc` plus the sign-extended constant times 4 (offsets -2^24 to 2^24-4).
- R5: When taken with `br_reg`=1, `target` is `rs_a` + `rs_b` modulo 2^32, with the condition rules of R1 and R2.
- R6: When `br_en`=0 or the predicate is false, `taken` is 0 and `target` is `pc` + 4.
- R7: A taken branch that issues (`issue_valid`=1) while no target is pending makes `slot_pending` 1 from the next cycle, and it stays 1 while no instruction issues.
- R8: In the cycle after the delay-slot instruction issues, `redirect_valid` is 1 for exactly one cycle and `redirect_pc` is the held target.
- R9: A taken branch issued in the delay slot is ignored: the redirect carries the first branch's target and nothing is pending afterwards.
- R10: During and right after reset, `slot_pending` and `redirect_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| br_en | input | 1 | The issuing instruction is a conditional branch |
| br_reg | input | 1 | Register variant: target is rs_a + rs_b |
| cond | input | 3 | Condition selector |
| inv | input | 1 | Negates the selected predicate |
| rel | input | 1 | 1 relative, 0 absolute constant target |
| imm | input | 23 | Word-scaled branch constant |
| pc | input | 32 | Address of the branch |
| rs_a | input | 32 | First register operand |
| rs_b | input | 32 | Second register operand |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| taken | output | 1 | Branch decision |
| target | output | 32 | Branch target if taken, else pc + 4 |
| slot_pending | output | 1 | A taken target waits for the delay slot |
| redirect_valid | output | 1 | Apply redirect_pc this cycle |
| redirect_pc | output | 32 | Held branch target |

## Verification
The bench uses the default widths: a 32-bit address and a 23-bit constant. At these widths the extreme constants are reachable, so the all-ones absolute constant gives 2^25-4 and the most negative relative offset gives -2^24. All sixteen selector codes are swept against all sixteen flag combinations. The sequencer is driven through back-to-back branches, stalls in the slot and branches placed in the slot.

// File: rtl/brc_pkg.sv
package brc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SLOT = 2'd1,
        ST_FIRE = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } flags_t;
endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
(
    input  flags_t     flags,
    input  logic [2:0] cond,
    input  logic       inv,
    output logic       pred
);
    logic base;

    always_comb begin
        unique case (cond)
            3'd0: base = 1'b1;
            3'd1: base = flags.c & ~flags.z;
            3'd2: base = ~flags.c;
            3'd3: base = ~flags.z;
            3'd4: base = ~flags.v;
            3'd5: base = ~flags.n;
            3'd6: base = (flags.n == flags.v);
            3'd7: base = (flags.n == flags.v) & ~flags.z;
            default: base = 1'b0;
        endcase
        pred = base ^ inv;
    end
endmodule

// File: rtl/brc_target_gen.sv
module brc_target_gen #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 23
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    input  logic             rel,
    input  logic             use_reg,
    input  logic [XLEN-1:0]  rs_a,
    input  logic [XLEN-1:0]  rs_b,
    input  logic             take,
    output logic [XLEN-1:0]  target
);
    localparam int PAD = XLEN - IMM_W - 2;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] abs_addr;
    logic [XLEN-1:0] rel_off;
    logic [XLEN-1:0] br_addr;

    always_comb begin
        abs_addr = {{PAD{1'b0}}, imm, 2'b00};
        rel_off  = {{PAD{imm[IMM_W-1]}}, imm, 2'b00};
        if (use_reg)
            br_addr = rs_a + rs_b;
        else if (rel)
            br_addr = pc + rel_off;
        else
            br_addr = abs_addr;
        target = take ? br_addr : (pc + STEP);
    end
endmodule

// File: rtl/brc_slot_fsm.sv
module brc_slot_fsm
    import brc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic            arm,
    input  logic [XLEN-1:0] tgt_in,
    output logic            slot_pending,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc
);
    slot_state_e state_q, state_d;
    logic [XLEN-1:0] hold_q;
    logic            do_arm;

    assign do_arm = issue_valid & arm & (state_q != ST_SLOT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (do_arm) state_d = ST_SLOT;
            ST_SLOT: if (issue_valid) state_d = ST_FIRE;
            ST_FIRE: state_d = do_arm ? ST_SLOT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (do_arm) hold_q <= tgt_in;
        end
    end

    always_comb begin
        slot_pending   = (state_q == ST_SLOT);
        redirect_valid = (state_q == ST_FIRE);
        redirect_pc    = hold_q;
    end

    AST_ARM_TO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && arm && !slot_pending) |=> slot_pending); // R7
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pending && !issue_valid) |=> (slot_pending && $stable(redirect_pc))); // R7
    AST_RELEASE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pending && issue_valid) |=> (redirect_valid && $stable(redirect_pc))); // R8
    AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid); // R8
    AST_SLOT_BRANCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pending && issue_valid && arm) |=> !slot_pending); // R9
endmodule

// File: rtl/brc_unit.sv
module brc_unit
    import brc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic             br_en,
    input  logic             br_reg,
    input  logic [2:0]       cond,
    input  logic             inv,
    input  logic             rel,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  rs_a,
    input  logic [XLEN-1:0]  rs_b,
    input  logic             flag_z,
    input  logic             flag_n,
    input  logic             flag_v,
    input  logic             flag_c,
    output logic             taken,
    output logic [XLEN-1:0]  target,
    output logic             slot_pending,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc
);
    flags_t flags;
    logic   pred;

    assign flags = '{z: flag_z, n: flag_n, v: flag_v, c: flag_c};
    assign taken = br_en & pred;

    brc_cond_eval u_cond (
        .flags (flags),
        .cond  (cond),
        .inv   (inv),
        .pred  (pred)
    );

    brc_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_tgt (
        .pc      (pc),
        .imm     (imm),
        .rel     (rel),
        .use_reg (br_reg),
        .rs_a    (rs_a),
        .rs_b    (rs_b),
        .take    (taken),
        .target  (target)
    );

    brc_slot_fsm #(.XLEN(XLEN)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .issue_valid    (issue_valid),
        .arm            (taken),
        .tgt_in         (target),
        .slot_pending   (slot_pending),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && cond == 3'd0 && !inv) |-> taken); // R1
    AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && cond == 3'd0 && inv) |-> !taken); // R2
    AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> (target == pc + XLEN'(4))); // R6
    AST_NO_BRANCH_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !br_en |-> !taken); // R6
endmodule

// File: tb/test_brc_unit.sv
module test_brc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0, br_en = 1'b0, br_reg = 1'b0, inv = 1'b0, rel = 1'b0;
    logic [2:0]  cond = '0;
    logic [22:0] imm = '0;
    logic [31:0] pc = '0, rs_a = '0, rs_b = '0;
    logic        flag_z = 1'b0, flag_n = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic        taken, slot_pending, redirect_valid;
    logic [31:0] target, redirect_pc;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        bit          tk;
        logic [31:0] tg;
        bit          sp;
        bit          rv;
        logic [31:0] rpc;
        string       req;
    } item_t;
    item_t sb[$];

    bit          m_pend = 0, m_redir = 0;
    logic [31:0] m_pt = '0, m_rt = '0;

    always #5 clk = ~clk;

    brc_unit i_brc_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .br_en(br_en),
        .br_reg(br_reg), .cond(cond), .inv(inv), .rel(rel), .imm(imm), .pc(pc),
        .rs_a(rs_a), .rs_b(rs_b), .flag_z(flag_z), .flag_n(flag_n),
        .flag_v(flag_v), .flag_c(flag_c), .taken(taken), .target(target),
        .slot_pending(slot_pending), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc)
    );

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit ref_pred(logic [3:0] code, bit z, bit n, bit v, bit c);
        case (code)
            4'b0000: return 1;
            4'b0001: return 0;
            4'b0010: return c && !z;
            4'b0011: return !c || z;
            4'b0100: return !c;
            4'b0101: return c;
            4'b0110: return !z;
            4'b0111: return z;
            4'b1000: return !v;
            4'b1001: return v;
            4'b1010: return !n;
            4'b1011: return n;
            4'b1100: return (n && v) || (!n && !v);
            4'b1101: return (n && !v) || (!n && v);
            4'b1110: return (n && v && !z) || (!n && !v && !z);
            default: return z || (n && !v) || (!n && v);
        endcase
    endfunction

    task automatic drive(bit vld, bit en, bit rg, logic [2:0] cd, bit iv, bit rl,
                         logic [22:0] k, logic [31:0] p, logic [31:0] a, logic [31:0] b,
                         logic [3:0] f, string req);
        item_t it;
        logic [31:0] bt;
        bit tk;
        @(negedge clk);
        #1;
        issue_valid = vld; br_en = en; br_reg = rg; cond = cd; inv = iv; rel = rl;
        imm = k; pc = p; rs_a = a; rs_b = b;
        {flag_z, flag_n, flag_v, flag_c} = f;
        tk = en && ref_pred({cd, iv}, f[3], f[2], f[1], f[0]);
        if (rg) bt = a + b;
        else if (rl) bt = p + 32'(signed'({{9{k[22]}}, k}) * 4);
        else bt = {9'd0, k} * 32'd4;
        it.tk = tk;
        it.tg = tk ? bt : p + 32'd4;
        it.sp = m_pend;
        it.rv = m_redir;
        it.rpc = m_rt;
        it.req = req;
        sb.push_back(it);
        if (m_pend) begin
            m_redir = vld;
            if (vld) begin
                m_rt = m_pt;
                m_pend = 0;
            end
        end else begin
            m_redir = 0;
            if (vld && tk) begin
                m_pend = 1;
                m_pt = it.tg;
            end
        end
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            #4;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                chk(taken == it.tk, it.req, "taken", 32'(taken), 32'(it.tk));
                chk(target == it.tg, it.req, "target", target, it.tg);
                chk(slot_pending == it.sp, it.req, "slot_pending", 32'(slot_pending), 32'(it.sp));
                chk(redirect_valid == it.rv, it.req, "redirect_valid", 32'(redirect_valid), 32'(it.rv));
                if (it.rv)
                    chk(redirect_pc == it.rpc, it.req, "redirect_pc", redirect_pc, it.rpc);
            end
        end
    end

    initial begin : watchdog
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        #2;
        chk(slot_pending == 0 && redirect_valid == 0, "R10", "in reset",
            {30'd0, slot_pending, redirect_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(0, 0, 0, 3'd0, 0, 0, 23'd0, 32'h100, 0, 0, 4'h0, "R10");

        // R1 / R2: every code against every flag pattern, no issue
        for (int f = 0; f < 16; f++)
            for (int code = 0; code < 16; code++)
                drive(0, 1, 0, 3'(code >> 1), code[0], 1, 23'h10, 32'h2000, 0, 0, 4'(f),
                      code[0] ? "R2" : "R1");

        // R3: absolute extremes
        drive(0, 1, 0, 3'd0, 0, 0, 23'h7FFFFF, 32'h1234, 0, 0, 4'h0, "R3");
        drive(0, 1, 0, 3'd0, 0, 0, 23'h000001, 32'h1234, 0, 0, 4'h0, "R3");
        // R4: relative extremes
        drive(0, 1, 0, 3'd0, 0, 1, 23'h400000, 32'h0100_0000, 0, 0, 4'h0, "R4");
        drive(0, 1, 0, 3'd0, 0, 1, 23'h3FFFFF, 32'h0000_0040, 0, 0, 4'h0, "R4");
        drive(0, 1, 0, 3'd0, 0, 1, 23'h7FFFFF, 32'h0000_0000, 0, 0, 4'h0, "R4");
        // R5: register sum, wraps, follows the condition
        drive(0, 1, 1, 3'd3, 0, 1, 23'h5, 32'h40, 32'hFFFF_FFF0, 32'h24, 4'h0, "R5");
        drive(0, 1, 1, 3'd3, 0, 0, 23'h5, 32'h40, 32'h1000, 32'h24, 4'h8, "R5");
        drive(0, 1, 1, 3'd7, 1, 0, 23'h5, 32'h40, 32'h1000, 32'h24, 4'h4, "R5");
        // R6: not a branch / false predicate
        drive(1, 0, 0, 3'd0, 0, 0, 23'h55, 32'hFFFF_FFFC, 0, 0, 4'h0, "R6");
        drive(1, 1, 0, 3'd3, 0, 0, 23'h55, 32'h300, 0, 0, 4'h8, "R6");
        drive(0, 0, 0, 3'd0, 0, 0, 0, 32'h304, 0, 0, 4'h0, "R6");

        // R7 / R8: taken branch, stalls, slot issues, redirect
        drive(1, 1, 0, 3'd0, 0, 0, 23'h200, 32'h400, 0, 0, 4'h0, "R7");
        drive(0, 0, 0, 3'd0, 0, 0, 0, 32'h404, 0, 0, 4'h0, "R7");
        drive(0, 0, 0, 3'd0, 0, 0, 0, 32'h404, 0, 0, 4'h0, "R7");
        drive(1, 0, 0, 3'd0, 0, 0, 0, 32'h404, 0, 0, 4'h0, "R8");
        drive(0, 0, 0, 3'd0, 0, 0, 0, 32'h800, 0, 0, 4'h0, "R8");
        drive(0, 0, 0, 3'd0, 0, 0, 0, 32'h800, 0, 0, 4'h0, "R8");

        // R9: branch in the slot is ignored
        drive(1, 1, 0, 3'd0, 0, 1, 23'h10, 32'h900, 0, 0, 4'h0, "R9");
        drive(1, 1, 0, 3'd0, 0, 0, 23'h3, 32'h904, 0, 0, 4'h0, "R9");
        drive(0, 0, 0, 3'd0, 0, 0, 0, 32'h940, 0, 0, 4'h0, "R9");
        drive(0, 0, 0, 3'd0, 0, 0, 0, 32'h940, 0, 0, 4'h0, "R9");

        // R8: back-to-back branch issued in the redirect cycle
        drive(1, 1, 1, 3'd0, 0, 0, 0, 32'hA00, 32'h50, 32'h50, 4'h0, "R8");
        drive(1, 0, 0, 3'd0, 0, 0, 0, 32'hA04, 0, 0, 4'h0, "R8");
        drive(1, 1, 0, 3'd0, 0, 0, 23'h40, 32'hA0, 0, 0, 4'h0, "R8");
        drive(1, 0, 0, 3'd0, 0, 0, 0, 32'hA4, 0, 0, 4'h0, "R8");
        drive(0, 0, 0, 3'd0, 0, 0, 0, 32'h100, 0, 0, 4'h0, "R8");
        drive(0, 0, 0, 3'd0, 0, 0, 0, 32'h100, 0, 0, 4'h0, "R8");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule